// File: doc/BRIEF.md
# Operand Address Resolver with Bit Read-Modify-Write

This block sits between the decode stage of an 8-bit microcontroller core and its two internal storage spaces: the internal data RAM and the special-function-register (SFR) file. It receives one operation at a time. Each operation carries a code, an 8-bit address field, the two register-bank bits of the status word and the current carry. The block turns the address field into a concrete storage access. The field can be a direct byte address, a working-register number, an indirect pointer selector or a bit address. For the bit operations the block then writes back the single addressed bit, leaving the rest of the byte as it was.

Both storage spaces share one access port. The port has a read strobe, a write strobe and a space select, and read data returns one cycle after the read strobe. For byte reads the block presents the byte it read. For every operation it presents the addressed bit of that byte. For the bit-to-carry operation it also pulses a carry write enable. The block asserts a busy flag from the cycle after it accepts an operation until the cycle of its done pulse. While busy is high, new requests are ignored.

The controller has seven states. `ST_IDLE` accepts a request. `ST_PTR_RD` and `ST_PTR_WAIT` fetch the R0/R1 pointer for indirect reads. `ST_OPND_RD` and `ST_OPND_WAIT` read the operand byte. `ST_WRITE_BACK` stores the modified byte, and `ST_FINISH` raises done. The transitions are as follows:
- IDLE→PTR_RD on an accepted indirect read, and IDLE→OPND_RD on any other accepted request.
- PTR_RD→PTR_WAIT→OPND_RD→OPND_WAIT.
- OPND_WAIT→WRITE_BACK for the four bit-writing operations, and OPND_WAIT→FINISH otherwise.
- WRITE_BACK→FINISH, then FINISH→IDLE.

Top module: `opnd_addr_unit`

## Requirements
- R1: While reset is held low, busy, done, mem_rd, mem_wr and carry_we are all 0.
- R2: Operation code 0 (direct read) reads internal RAM when the address is below 0x80. For 0x80 and above it reads the SFR space (mem_sfr=1). rd_byte holds the byte read, and done rises on the third clock edge after the accepting edge.
- R3: Operation code 1 (register read) reads RAM address bank*8 + n, where bank is the 2-bit bank input and n is the low three bits of the address field.
- R4: Operation code 2 (indirect read) first reads R0 or R1 of the current bank, chosen by address bit 0. It then reads internal RAM at that 8-bit pointer, even when the pointer is 0x80 or above. done rises on the fifth edge after acceptance.
- R5: A bit address below 128 selects RAM byte 0x20 + (address / 8). A bit address of 128 or above selects SFR byte (address AND 0xF8). The bit within the byte is address AND 7.
- R6: Operation codes 3 (set), 4 (clear) and 5 (complement) read the byte, then write it back with only the addressed bit changed. Done comes on the fourth edge after acceptance, and bit_val reports the bit's value before the change.
- R7: Operation code 6 (bit to carry) pulses carry_we together with done, with carry_out equal to the addressed bit. It never writes storage, and done comes on the third edge.
- R8: Operation code 7 (carry to bit) writes the carry latched at acceptance into the addressed bit. All other bits are unchanged.
- R9: busy is high from the edge that accepts a request through the done cycle. A request presented while busy is high has no effect.
- R10: done is a single-cycle pulse, and mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 3 | Operation code (0..7) |
| req_addr | input | 8 | Direct address, register number, pointer selector or bit address |
| bank_sel | input | 2 | Register-bank bits of the status word |
| carry_in | input | 1 | Current carry flag |
| busy | output | 1 | Operation in progress |
| mem_rd | output | 1 | Storage read strobe |
| mem_wr | output | 1 | Storage write strobe |
| mem_sfr | output | 1 | 1 selects the SFR space, 0 internal RAM |
| mem_addr | output | 8 | Storage byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| done | output | 1 | Completion pulse |
| rd_byte | output | 8 | Byte read by the operation |
| bit_val | output | 1 | Addressed bit as read (before modification) |
| carry_out | output | 1 | New carry value for the bit-to-carry operation |
| carry_we | output | 1 | Carry write enable |

## Verification
The case hardest to provoke from the ports is a second request arriving while an operation is in flight. The bench raises a bit-set request in the cycle right after a read is accepted. It then reads the target byte back from its storage model, and counts write strobes, to show that nothing was written. A second hard case is an indirect pointer whose value lies at 0x80 or above. There the bench fills the SFR byte and the RAM byte at the same index with different values, so that only a RAM access returns the expected byte.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    typedef enum logic [2:0] {
        OP_DIR_RD   = 3'd0,
        OP_REG_RD   = 3'd1,
        OP_IND_RD   = 3'd2,
        OP_BIT_SET  = 3'd3,
        OP_BIT_CLR  = 3'd4,
        OP_BIT_CPL  = 3'd5,
        OP_BIT_TO_C = 3'd6,
        OP_C_TO_BIT = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR_RD,
        ST_PTR_WAIT,
        ST_OPND_RD,
        ST_OPND_WAIT,
        ST_WRITE_BACK,
        ST_FINISH
    } state_e;

    function automatic logic op_writes(op_e op);
        return (op == OP_BIT_SET) || (op == OP_BIT_CLR) ||
               (op == OP_BIT_CPL) || (op == OP_C_TO_BIT);
    endfunction

endpackage

// File: rtl/opnd_addr_map.sv
module opnd_addr_map
    import opnd_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 8,
    parameter int unsigned       DATA_W   = 8,
    parameter logic [ADDR_W-1:0] BIT_BASE = 'h20
) (
    input  op_e                            op,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [1:0]                     bank,
    input  logic [ADDR_W-1:0]              ptr,
    output logic [ADDR_W-1:0]              eff_addr,
    output logic [ADDR_W-1:0]              ptr_addr,
    output logic                           is_sfr,
    output logic [$clog2(DATA_W)-1:0]      bit_idx
);
    localparam int unsigned IDX_W = $clog2(DATA_W);

    // pointer register R0/R1 of the selected bank
    assign ptr_addr = ADDR_W'({bank, 2'b00, addr[0]});
    assign bit_idx  = addr[IDX_W-1:0];

    always_comb begin
        eff_addr = addr;
        is_sfr   = 1'b0;
        unique case (op)
            OP_DIR_RD: begin
                is_sfr   = addr[ADDR_W-1];
                eff_addr = addr;
            end
            OP_REG_RD: begin
                eff_addr = ADDR_W'({bank, addr[2:0]});
            end
            OP_IND_RD: begin
                eff_addr = ptr;
            end
            default: begin
                if (addr[ADDR_W-1]) begin
                    is_sfr   = 1'b1;
                    eff_addr = {addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
                end else begin
                    eff_addr = BIT_BASE + (addr >> IDX_W);
                end
            end
        endcase
    end
endmodule

// File: rtl/opnd_bit_modify.sv
module opnd_bit_modify
    import opnd_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  op_e                         op,
    input  logic [DATA_W-1:0]           byte_in,
    input  logic [$clog2(DATA_W)-1:0]   bit_idx,
    input  logic                        carry,
    output logic [DATA_W-1:0]           byte_out,
    output logic                        bit_old
);
    logic [DATA_W-1:0] mask;

    assign mask    = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;
    assign bit_old = |(byte_in & mask);

    always_comb begin
        unique case (op)
            OP_BIT_SET:  byte_out = byte_in | mask;
            OP_BIT_CLR:  byte_out = byte_in & ~mask;
            OP_BIT_CPL:  byte_out = byte_in ^ mask;
            OP_C_TO_BIT: byte_out = carry ? (byte_in | mask) : (byte_in & ~mask);
            default:     byte_out = byte_in;
        endcase
    end
endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
    import opnd_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 8,
    parameter int unsigned       DATA_W   = 8,
    parameter logic [ADDR_W-1:0] BIT_BASE = 'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        bank_sel,
    input  logic              carry_in,
    output logic              busy,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_sfr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_byte,
    output logic              bit_val,
    output logic              carry_out,
    output logic              carry_we
);
    localparam int unsigned IDX_W = $clog2(DATA_W);

    state_e            state, state_nx;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        bank_q;
    logic              carry_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [DATA_W-1:0] byte_q;

    logic [ADDR_W-1:0] eff_addr, ptr_addr;
    logic              is_sfr;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] byte_new;
    logic              bit_old;

    opnd_addr_map #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .BIT_BASE (BIT_BASE)
    ) u_map (
        .op       (op_q),
        .addr     (addr_q),
        .bank     (bank_q),
        .ptr      (ptr_q),
        .eff_addr (eff_addr),
        .ptr_addr (ptr_addr),
        .is_sfr   (is_sfr),
        .bit_idx  (bit_idx)
    );

    opnd_bit_modify #(
        .DATA_W (DATA_W)
    ) u_mod (
        .op       (op_q),
        .byte_in  (byte_q),
        .bit_idx  (bit_idx),
        .carry    (carry_q),
        .byte_out (byte_new),
        .bit_old  (bit_old)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid)
                    state_nx = (op_e'(req_op) == OP_IND_RD) ? ST_PTR_RD : ST_OPND_RD;
            end
            ST_PTR_RD:     state_nx = ST_PTR_WAIT;
            ST_PTR_WAIT:   state_nx = ST_OPND_RD;
            ST_OPND_RD:    state_nx = ST_OPND_WAIT;
            ST_OPND_WAIT:  state_nx = op_writes(op_q) ? ST_WRITE_BACK : ST_FINISH;
            ST_WRITE_BACK: state_nx = ST_FINISH;
            ST_FINISH:     state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // operand and data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_DIR_RD;
            addr_q  <= '0;
            bank_q  <= '0;
            carry_q <= 1'b0;
            ptr_q   <= '0;
            byte_q  <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                op_q    <= op_e'(req_op);
                addr_q  <= req_addr;
                bank_q  <= bank_sel;
                carry_q <= carry_in;
            end
            if (state == ST_PTR_WAIT)  ptr_q  <= ADDR_W'(mem_rdata);
            if (state == ST_OPND_WAIT) byte_q <= mem_rdata;
        end
    end

    // outputs
    always_comb begin
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        mem_sfr  = 1'b0;
        mem_addr = '0;
        done     = 1'b0;
        carry_we = 1'b0;
        unique case (state)
            ST_PTR_RD: begin
                mem_rd   = 1'b1;
                mem_addr = ptr_addr;
            end
            ST_OPND_RD: begin
                mem_rd   = 1'b1;
                mem_sfr  = is_sfr;
                mem_addr = eff_addr;
            end
            ST_WRITE_BACK: begin
                mem_wr   = 1'b1;
                mem_sfr  = is_sfr;
                mem_addr = eff_addr;
            end
            ST_FINISH: begin
                done     = 1'b1;
                carry_we = (op_q == OP_BIT_TO_C);
            end
            default: ;
        endcase
    end

    assign busy      = (state != ST_IDLE);
    assign mem_wdata = byte_new;
    assign rd_byte   = byte_q;
    assign bit_val   = bit_old;
    assign carry_out = bit_old;

endmodule

// File: rtl/opnd_addr_unit_chk.sv
module opnd_addr_unit_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_sfr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              carry_we
);
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr && !done));

    assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd, 2) && $past(mem_addr, 2) == mem_addr &&
                    $past(mem_sfr, 2) == mem_sfr));

    assert_ram_bit_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_sfr) |-> (mem_addr[ADDR_W-1:4] == 'h2));

    assert_sfr_bit_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_sfr) |-> (mem_addr[2:0] == 3'b000));

    assert_sfr_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sfr && (mem_rd || mem_wr)) |-> mem_addr[ADDR_W-1]);

    assert_carry_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        carry_we |-> (done && !mem_wr));

endmodule

bind opnd_addr_unit opnd_addr_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_sfr   (mem_sfr),
    .mem_addr  (mem_addr),
    .done      (done),
    .carry_we  (carry_we)
);

// File: tb/opnd_addr_unit_bench.sv
`timescale 1ns/1ps
module opnd_addr_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [7:0] req_addr = 8'h00;
    logic [1:0] bank_sel = 2'd0;
    logic       carry_in = 1'b0;
    logic       busy, mem_rd, mem_wr, mem_sfr, done, bit_val, carry_out, carry_we;
    logic [7:0] mem_addr, mem_wdata, rd_byte;
    logic [7:0] mem_rdata = 8'h00;

    logic [7:0] ram [256];
    logic [7:0] sfr [128];
    int wr_count = 0;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    opnd_addr_unit u_opnd_addr_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .bank_sel(bank_sel), .carry_in(carry_in),
        .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_sfr(mem_sfr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .rd_byte(rd_byte), .bit_val(bit_val),
        .carry_out(carry_out), .carry_we(carry_we)
    );

    // storage model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem_sfr ? sfr[mem_addr[6:0]] : ram[mem_addr];
        if (mem_wr) begin
            wr_count <= wr_count + 1;
            if (mem_sfr) sfr[mem_addr[6:0]] <= mem_wdata;
            else         ram[mem_addr] <= mem_wdata;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] a,
                         input logic [1:0] bk, input logic c,
                         output int lat, output logic [7:0] rb, output logic bv,
                         output logic cwe, output logic cout, output logic done_after);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; bank_sel = bk; carry_in = c;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; carry_in = ~c;
        lat = 1;
        while (!done && lat < 20) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        rb = rd_byte; bv = bit_val; cwe = carry_we; cout = carry_out;
        @(posedge clk);
        @(negedge clk);
        done_after = done;
    endtask

    task automatic t_reset();
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "mem_rd", mem_rd, 0);
        check("R1", "mem_wr", mem_wr, 0);
        check("R1", "carry_we", carry_we, 0);
    endtask

    task automatic t_direct();
        int lat; logic [7:0] rb; logic bv, cwe, co, da;
        ram[8'h45] = 8'h5A; ram[8'h7F] = 8'h11; ram[8'h80] = 8'h99; sfr[0] = 8'h22;
        sfr[8'h10] = 8'hC3;
        issue(3'd0, 8'h45, 2'd0, 1'b0, lat, rb, bv, cwe, co, da);
        check("R2", "ram byte", rb, 8'h5A);
        check("R2", "latency", lat, 3);
        check("R10", "done pulse", da, 0);
        issue(3'd0, 8'h90, 2'd0, 1'b0, lat, rb, bv, cwe, co, da);
        check("R2", "sfr byte", rb, 8'hC3);
        issue(3'd0, 8'h7F, 2'd0, 1'b0, lat, rb, bv, cwe, co, da);
        check("R2", "boundary 7F", rb, 8'h11);
        issue(3'd0, 8'h80, 2'd0, 1'b0, lat, rb, bv, cwe, co, da);
        check("R2", "boundary 80 is sfr", rb, 8'h22);
    endtask

    task automatic t_register();
        int lat; logic [7:0] rb; logic bv, cwe, co, da;
        for (int i = 0; i < 32; i++) ram[i] = 8'(8'h40 + i);
        issue(3'd1, 8'h05, 2'd2, 1'b0, lat, rb, bv, cwe, co, da);
        check("R3", "bank2 r5", rb, 8'h55);
        issue(3'd1, 8'hFF, 2'd3, 1'b0, lat, rb, bv, cwe, co, da);
        check("R3", "bank3 r7", rb, 8'h5F);
        issue(3'd1, 8'h00, 2'd0, 1'b0, lat, rb, bv, cwe, co, da);
        check("R3", "bank0 r0", rb, 8'h40);
    endtask

    task automatic t_indirect();
        int lat; logic [7:0] rb; logic bv, cwe, co, da;
        ram[8'h08] = 8'h30; ram[8'h09] = 8'hA0;
        ram[8'h30] = 8'h77; ram[8'hA0] = 8'h88; sfr[8'h20] = 8'hEE;
        issue(3'd2, 8'h00, 2'd1, 1'b0, lat, rb, bv, cwe, co, da);
        check("R4", "via r0", rb, 8'h77);
        check("R4", "latency", lat, 5);
        issue(3'd2, 8'h01, 2'd1, 1'b0, lat, rb, bv, cwe, co, da);
        check("R4", "via r1 high ram", rb, 8'h88);
    endtask

    task automatic t_bit_ops();
        int lat; int w0; logic [7:0] rb; logic bv, cwe, co, da;
        ram[8'h2F] = 8'h00; w0 = wr_count;
        issue(3'd3, 8'h7F, 2'd0, 1'b0, lat, rb, bv, cwe, co, da);
        check("R5", "set bit 7F -> ram 2F", ram[8'h2F], 8'h80);
        check("R6", "set latency", lat, 4);
        check("R6", "single write", wr_count - w0, 1);
        check("R6", "old bit", bv, 0);
        ram[8'h20] = 8'hFF;
        issue(3'd4, 8'h03, 2'd0, 1'b0, lat, rb, bv, cwe, co, da);
        check("R6", "clear bit 03", ram[8'h20], 8'hF7);
        check("R6", "old bit set", bv, 1);
        sfr[8'h50] = 8'h0F;
        issue(3'd5, 8'hD5, 2'd0, 1'b0, lat, rb, bv, cwe, co, da);
        check("R5", "cpl sfr D0 bit5", sfr[8'h50], 8'h2F);
        issue(3'd5, 8'hD5, 2'd0, 1'b0, lat, rb, bv, cwe, co, da);
        check("R6", "cpl back", sfr[8'h50], 8'h0F);
    endtask

    task automatic t_to_carry();
        int lat; int w0; logic [7:0] rb; logic bv, cwe, co, da;
        sfr[8'h60] = 8'h04; w0 = wr_count;
        issue(3'd6, 8'hE2, 2'd0, 1'b0, lat, rb, bv, cwe, co, da);
        check("R7", "carry_we", cwe, 1);
        check("R7", "carry_out", co, 1);
        check("R7", "latency", lat, 3);
        issue(3'd6, 8'hE3, 2'd0, 1'b1, lat, rb, bv, cwe, co, da);
        check("R7", "carry_out zero", co, 0);
        check("R7", "no write", wr_count - w0, 0);
        check("R7", "byte kept", sfr[8'h60], 8'h04);
    endtask

    task automatic t_from_carry();
        int lat; logic [7:0] rb; logic bv, cwe, co, da;
        ram[8'h25] = 8'h00;
        issue(3'd7, 8'h2C, 2'd0, 1'b1, lat, rb, bv, cwe, co, da);
        check("R8", "carry 1 into bit 2C", ram[8'h25], 8'h10);
        check("R8", "carry_we quiet", cwe, 0);
        issue(3'd7, 8'h2C, 2'd0, 1'b0, lat, rb, bv, cwe, co, da);
        check("R8", "carry 0 into bit 2C", ram[8'h25], 8'h00);
        ram[8'h25] = 8'hFF;
        issue(3'd7, 8'h29, 2'd0, 1'b0, lat, rb, bv, cwe, co, da);
        check("R8", "others kept", ram[8'h25], 8'hFD);
    endtask

    task automatic t_busy();
        int w0; int n;
        ram[8'h21] = 8'h00; ram[8'h45] = 8'h5A; w0 = wr_count;
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd0; req_addr = 8'h45; bank_sel = 2'd0;
        @(posedge clk);
        @(negedge clk);
        check("R9", "busy after accept", busy, 1);
        req_op = 3'd3; req_addr = 8'h08;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 20) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        check("R9", "busy through done", busy, 1);
        check("R9", "read result", rd_byte, 8'h5A);
        repeat (6) @(negedge clk);
        check("R9", "ignored request no write", wr_count - w0, 0);
        check("R9", "ignored request byte", ram[8'h21], 8'h00);
        check("R9", "idle again", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = 8'h00;
        for (int i = 0; i < 128; i++) sfr[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_direct();
        t_register();
        t_indirect();
        t_bit_ops();
        t_to_carry();
        t_from_carry();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule